// File: doc/BRIEF.md
# Store Queue with Store-to-Load Forwarding

This block buffers a core's committed stores in an eight-entry, program-ordered queue. It writes them one per cycle into a data cache through a drain port. Every load is compared against the buffered stores before it reaches the cache. The youngest store that shares any byte with the load decides the result:

- If that store starts at the same byte as the load and is at least as wide, its data is returned in the same cycle.
- If it overlaps in any other way, the load is refused and retried every cycle. Once that store has been written to the cache, the load reads the cache.
- A load that meets no buffered store reads the cache at once.

All accesses are 1, 2, 4 or 8 bytes and naturally aligned inside a 64-bit word. A counter reports how many cycles the current load has been held back, so the cost of a failed forward can be seen.

Top module: `stlf_unit`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `dr_valid` is 0, `ld_wait` is 0 and no load is stalled.
- R2: A store is accepted on a cycle where `st_valid` and `st_ready` are both 1. `st_ready` is 0 while `DEPTH` stores are held. A store offered while the queue is full is dropped and never drains.
- R3: While the queue holds a store, `dr_valid` is 1 and the port presents the oldest store. `dr_addr` is the address with its three low bits removed. `dr_mask` has one bit per byte of the word (bit n = byte n). `dr_data` carries the store's low bytes moved up to their byte offset, with all other bytes zero. One store leaves per cycle on which `dr_ready` is 1, in program order.
- R4: Sizes use the encoding 0, 1, 2, 3 for 1, 2, 4, 8 bytes. A load that shares no byte with any buffered store completes in the same cycle (`ld_done`=1, `ld_fwd`=0). It returns bytes from `cr_data` of word `cr_addr`, shifted down by the load's byte offset, with everything above the load size zero.
- R5: A load whose address and size equal those of the youngest overlapping store completes in the same cycle with `ld_fwd`=1 and that store's data.
- R6: A load narrower than the youngest overlapping store forwards that store's low bytes when both begin at the same address.
- R7: A load that meets the youngest overlapping store at any byte other than that store's first byte stalls (`ld_stall`=1, `ld_done`=0). Once that store has drained, the load completes from the cache.
- R8: A load wider than the youngest overlapping store stalls until that store has drained. It then reads the cache, which holds the merged bytes.
- R9: Only the youngest overlapping store decides the outcome. An older store that could have forwarded does not prevent a stall, and an older store that blocks does not prevent a forward.
- R10: `ld_wait` counts the cycles on which `ld_stall` was 1 for the current load, so on the completing cycle it equals the number of stalled cycles. It returns to 0 on the cycle after a load completes.
- R11: While `dr_ready` is 0, no store leaves the queue, and a load blocked by a buffered store stays stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | AW | Store byte address, aligned to its size |
| st_size | input | 2 | Store size code (0..3 = 1..8 bytes) |
| st_data | input | 64 | Store data, right-justified |
| st_ready | output | 1 | Queue has a free entry |
| ld_valid | input | 1 | Load request, held until done |
| ld_addr | input | AW | Load byte address, aligned to its size |
| ld_size | input | 2 | Load size code |
| ld_done | output | 1 | Load completes this cycle |
| ld_fwd | output | 1 | Completing data comes from a buffered store |
| ld_stall | output | 1 | Load blocked by a buffered store, retry |
| ld_data | output | 64 | Load data, right-justified, zero-extended |
| ld_wait | output | CNTW | Stalled cycles of the current load |
| cr_addr | output | AW-3 | Cache read word address |
| cr_data | input | 64 | Cache read word, same cycle |
| dr_valid | output | 1 | Oldest store presented to the cache |
| dr_ready | input | 1 | Cache accepts the drain this cycle |
| dr_addr | output | AW-3 | Drain word address |
| dr_mask | output | 8 | Drain byte enables |
| dr_data | output | 64 | Drain data at byte positions |

## Verification
Several rules hold on every cycle, and the assertions check them continuously:
- The occupancy changes exactly by the accepted pushes and pops and never exceeds the depth.
- A stalled load always has a store on offer at the drain port, so a stall can always make progress.
- The wait counter steps by one per stalled cycle and clears after completion.
- Completed load data carries no bits above the load size.

Other behaviour depends on particular store and load sequences, and only the bench's directed scenarios show it:
- Which store is judged youngest.
- Whether an offset or size pairing forwards or stalls.
- The exact number of stall cycles as drains free the way.
- The merged bytes read from the cache after draining.

// File: rtl/stlf_pkg.sv
package stlf_pkg;

  localparam int WORD_BYTES = 8;
  localparam int WORD_BITS  = 64;

  // Byte enables of an aligned access of size code sz at byte offset off.
  function automatic logic [7:0] byte_mask(input logic [2:0] off, input logic [1:0] sz);
    logic [7:0] base;
    case (sz)
      2'd0:    base = 8'h01;
      2'd1:    base = 8'h03;
      2'd2:    base = 8'h0F;
      default: base = 8'hFF;
    endcase
    return base << off;
  endfunction

  // Bit mask covering the low bytes of a right-justified value of size code sz.
  function automatic logic [63:0] data_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

  // Bit shift for a byte offset within the word.
  function automatic logic [5:0] lane_shift(input logic [2:0] off);
    return {off, 3'b000};
  endfunction

endpackage

// File: rtl/stlf_queue.sv
module stlf_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [1:0]                   push_size,
  input  logic [63:0]                  push_data,
  input  logic                         pop,
  output logic [CW-1:0]                count,
  output logic [DEPTH-1:0]             age_vld,
  output logic [DEPTH-1:0][AW-1:0]     age_addr,
  output logic [DEPTH-1:0][1:0]        age_size,
  output logic [DEPTH-1:0][63:0]       age_data
);

  logic [DEPTH-1:0][AW-1:0] m_addr;
  logic [DEPTH-1:0][1:0]    m_size;
  logic [DEPTH-1:0][63:0]   m_data;
  logic [PW-1:0]            head, tail;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      m_addr[tail] <= push_addr;
      m_size[tail] <= push_size;
      m_data[tail] <= push_data;
    end
  end

  // Present entries by age: index 0 is the oldest.
  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    logic [PW:0]   sum;
    logic [PW-1:0] idx;
    assign sum = {1'b0, head} + (PW + 1)'(i);
    assign idx = (sum >= (PW + 1)'(DEPTH)) ? PW'(sum - (PW + 1)'(DEPTH)) : sum[PW-1:0];
    assign age_vld[i]  = CW'(i) < count;
    assign age_addr[i] = m_addr[idx];
    assign age_size[i] = m_size[idx];
    assign age_data[i] = m_data[idx];
  end

endmodule

// File: rtl/stlf_match.sv
module stlf_match
  import stlf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]             age_vld,
  input  logic [DEPTH-1:0][AW-1:0]     age_addr,
  input  logic [DEPTH-1:0][1:0]        age_size,
  input  logic [AW-1:0]                ld_addr,
  input  logic [1:0]                   ld_size,
  output logic [DEPTH-1:0]             ovl_vec,
  output logic                         any_ovl,
  output logic [PW-1:0]                sel,
  output logic                         fwd_ok
);

  logic [7:0] ld_mask;
  assign ld_mask = byte_mask(ld_addr[2:0], ld_size);

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    logic same_word;
    assign same_word  = age_addr[i][AW-1:3] == ld_addr[AW-1:3];
    assign ovl_vec[i] = age_vld[i] && same_word &&
                        (|(byte_mask(age_addr[i][2:0], age_size[i]) & ld_mask));
  end

  // Youngest overlapping entry wins: the highest age index.
  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ovl_vec[i]) sel = PW'(i);
    end
  end

  assign any_ovl = |ovl_vec;
  assign fwd_ok  = any_ovl && (age_addr[sel] == ld_addr) && (ld_size <= age_size[sel]);

endmodule

// File: rtl/stlf_unit.sv
module stlf_unit
  import stlf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int CNTW  = 16,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_valid,
  input  logic [AW-1:0]   st_addr,
  input  logic [1:0]      st_size,
  input  logic [63:0]     st_data,
  output logic            st_ready,
  input  logic            ld_valid,
  input  logic [AW-1:0]   ld_addr,
  input  logic [1:0]      ld_size,
  output logic            ld_done,
  output logic            ld_fwd,
  output logic            ld_stall,
  output logic [63:0]     ld_data,
  output logic [CNTW-1:0] ld_wait,
  output logic [AW-4:0]   cr_addr,
  input  logic [63:0]     cr_data,
  output logic            dr_valid,
  input  logic            dr_ready,
  output logic [AW-4:0]   dr_addr,
  output logic [7:0]      dr_mask,
  output logic [63:0]     dr_data
);

  // Internal events, named for the checker.
  logic                     push, pop;
  logic [CW-1:0]            q_count;
  logic [DEPTH-1:0]         age_vld, ovl_vec;
  logic [DEPTH-1:0][AW-1:0] age_addr;
  logic [DEPTH-1:0][1:0]    age_size;
  logic [DEPTH-1:0][63:0]   age_data;
  logic                     any_ovl, fwd_ok;
  logic [PW-1:0]            sel;

  assign st_ready = q_count < CW'(DEPTH);
  assign push     = st_valid && st_ready;
  assign dr_valid = q_count != '0;
  assign pop      = dr_valid && dr_ready;

  stlf_queue #(.DEPTH(DEPTH), .AW(AW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_addr (st_addr),
    .push_size (st_size),
    .push_data (st_data),
    .pop       (pop),
    .count     (q_count),
    .age_vld   (age_vld),
    .age_addr  (age_addr),
    .age_size  (age_size),
    .age_data  (age_data)
  );

  stlf_match #(.DEPTH(DEPTH), .AW(AW)) u_match (
    .age_vld  (age_vld),
    .age_addr (age_addr),
    .age_size (age_size),
    .ld_addr  (ld_addr),
    .ld_size  (ld_size),
    .ovl_vec  (ovl_vec),
    .any_ovl  (any_ovl),
    .sel      (sel),
    .fwd_ok   (fwd_ok)
  );

  // Drain port: oldest entry, data moved to its byte lanes.
  assign dr_addr = age_addr[0][AW-1:3];
  assign dr_mask = byte_mask(age_addr[0][2:0], age_size[0]);
  assign dr_data = (age_data[0] & data_mask(age_size[0])) << lane_shift(age_addr[0][2:0]);

  // Load outcome.
  assign cr_addr  = ld_addr[AW-1:3];
  assign ld_stall = ld_valid && any_ovl && !fwd_ok;
  assign ld_fwd   = ld_valid && fwd_ok;
  assign ld_done  = ld_valid && !ld_stall;

  always_comb begin
    if (!ld_done)
      ld_data = '0;
    else if (fwd_ok)
      ld_data = age_data[sel] & data_mask(ld_size);
    else
      ld_data = (cr_data >> lane_shift(ld_addr[2:0])) & data_mask(ld_size);
  end

  // Stall latency counter, saturating.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ld_wait <= '0;
    else if (ld_stall) begin
      if (ld_wait != '1) ld_wait <= ld_wait + CNTW'(1);
    end else if (ld_done)
      ld_wait <= '0;
  end

endmodule

// File: rtl/stlf_unit_chk.sv
module stlf_unit_chk
  import stlf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNTW  = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            push,
  input logic            pop,
  input logic [CW-1:0]   q_count,
  input logic            ld_stall,
  input logic            ld_done,
  input logic [CNTW-1:0] ld_wait,
  input logic [1:0]      ld_size,
  input logic [63:0]     ld_data,
  input logic            dr_valid,
  input logic [7:0]      dr_mask
);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  // R2
  occupancy_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (int'(q_count) == int'($past(q_count)) + int'($past(push)) - int'($past(pop))));

  // R11
  stall_has_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> dr_valid);

  // R3
  drain_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_valid |-> (dr_mask != 8'h00));

  // R10
  wait_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stall && ld_wait != '1) |=> (ld_wait == $past(ld_wait) + CNTW'(1)));

  // R10
  wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |=> (ld_wait == '0));

  // R4
  zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> ((ld_data & ~data_mask(ld_size)) == 64'd0));

endmodule

bind stlf_unit stlf_unit_chk #(.DEPTH(DEPTH), .CNTW(CNTW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .push     (push),
  .pop      (pop),
  .q_count  (q_count),
  .ld_stall (ld_stall),
  .ld_done  (ld_done),
  .ld_wait  (ld_wait),
  .ld_size  (ld_size),
  .ld_data  (ld_data),
  .dr_valid (dr_valid),
  .dr_mask  (dr_mask)
);

// File: tb/stlf_unit_tb.sv
`timescale 1ns/1ps
module stlf_unit_tb;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        st_valid = 0;
  logic [31:0] st_addr = '0;
  logic [1:0]  st_size = '0;
  logic [63:0] st_data = '0;
  logic        st_ready;
  logic        ld_valid = 0;
  logic [31:0] ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic        ld_done, ld_fwd, ld_stall;
  logic [63:0] ld_data;
  logic [15:0] ld_wait;
  logic [28:0] cr_addr;
  logic [63:0] cr_data;
  logic        dr_valid;
  logic        dr_ready = 0;
  logic [28:0] dr_addr;
  logic [7:0]  dr_mask;
  logic [63:0] dr_data;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  stlf_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .st_ready(st_ready),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_done(ld_done), .ld_fwd(ld_fwd), .ld_stall(ld_stall), .ld_data(ld_data),
    .ld_wait(ld_wait),
    .cr_addr(cr_addr), .cr_data(cr_data),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_addr(dr_addr),
    .dr_mask(dr_mask), .dr_data(dr_data)
  );

  // Simple cache model: 32 words, byte i of word w starts as w*16+i.
  logic [63:0] mem [32];
  assign cr_data = mem[cr_addr[4:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 32; w++)
        for (int b = 0; b < 8; b++) mem[w][b*8 +: 8] <= 8'(w * 16 + b);
    end else if (dr_valid && dr_ready) begin
      for (int b = 0; b < 8; b++)
        if (dr_mask[b]) mem[dr_addr[4:0]][b*8 +: 8] <= dr_data[b*8 +: 8];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic enq(input logic [31:0] a, input logic [1:0] sz, input logic [63:0] d);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_size = sz; st_data = d;
    #2 chk(st_ready == 1'b1, "R2", "store accepted", 64'(st_ready), 64'd1);
    @(negedge clk);
    st_valid = 0;
  endtask

  task automatic flush();
    @(negedge clk);
    dr_ready = 1;
    for (int i = 0; i < 20 && dr_valid; i++) @(negedge clk);
    dr_ready = 0;
  endtask

  // Hold a load until done; raise dr_ready on cycle rel (never if rel < 0).
  task automatic run_load(input logic [31:0] a, input logic [1:0] sz, input int rel,
                          input int exp_st, input logic [63:0] exp_d, input bit exp_f,
                          input string req);
    int  stalls = 0;
    bit  fin = 0;
    @(negedge clk);
    ld_valid = 1; ld_addr = a; ld_size = sz;
    for (int cyc = 0; !fin; cyc++) begin
      if (cyc == rel) dr_ready = 1;
      #2;
      if (ld_stall) begin
        stalls++;
        if (ld_done) chk(0, req, "done while stalled", 64'(ld_done), 64'd0);
        if (cyc > 60) begin
          chk(0, req, "load never completed", 64'(stalls), 64'(exp_st));
          fin = 1;
        end
      end else begin
        chk(ld_done == 1'b1, req, "load done", 64'(ld_done), 64'd1);
        chk(ld_data == exp_d, req, "load data", ld_data, exp_d);
        chk(ld_fwd == exp_f, req, "forward flag", 64'(ld_fwd), 64'(exp_f));
        chk(stalls == exp_st, req, "stall cycles", 64'(stalls), 64'(exp_st));
        chk(ld_wait == 16'(stalls), "R10", "wait counter at completion", 64'(ld_wait), 64'(stalls));
        fin = 1;
      end
      @(negedge clk);
    end
    ld_valid = 0;
    #2 chk(ld_wait == 16'd0, "R10", "wait counter cleared", 64'(ld_wait), 64'd0);
  endtask

  task automatic t_reset();
    chk(st_ready == 1'b1, "R1", "st_ready after reset", 64'(st_ready), 64'd1);
    chk(dr_valid == 1'b0, "R1", "dr_valid after reset", 64'(dr_valid), 64'd0);
    chk(ld_wait == 16'd0, "R1", "ld_wait after reset", 64'(ld_wait), 64'd0);
    chk(ld_stall == 1'b0, "R1", "no stall after reset", 64'(ld_stall), 64'd0);
  endtask

  task automatic t_cache_only();
    // R4: empty queue, several sizes and offsets
    run_load(32'h28, 2'd2, -1, 0, 64'h5352_5150, 0, "R4");
    run_load(32'h30, 2'd3, -1, 0, 64'h6766_6564_6362_6160, 0, "R4");
    run_load(32'h3F, 2'd0, -1, 0, 64'h77, 0, "R4");
    run_load(32'h3A, 2'd1, -1, 0, 64'h7372, 0, "R4");
  endtask

  task automatic t_forward();
    dr_ready = 0;
    enq(32'h44, 2'd2, 64'h0BAD_F00D_DEAD_BEEF);
    enq(32'h48, 2'd3, 64'h1122_3344_5566_7788);
    run_load(32'h44, 2'd2, -1, 0, 64'hDEAD_BEEF, 1, "R5");
    run_load(32'h48, 2'd0, -1, 0, 64'h88, 1, "R6");
    run_load(32'h48, 2'd1, -1, 0, 64'h7788, 1, "R6");
    // R7: byte 3 of the 8-byte store; R11: held while dr_ready is low
    run_load(32'h4B, 2'd0, 3, 5, 64'h55, 0, "R7");
    flush();
  endtask

  task automatic t_wide_load();
    dr_ready = 0;
    enq(32'h61, 2'd0, 64'hFFFF_FFFF_FFFF_FFAB);
    run_load(32'h60, 2'd2, 2, 3, 64'hC3C2_ABC0, 0, "R8");
    flush();
  endtask

  task automatic t_youngest();
    dr_ready = 0;
    // R9: older covering store, younger narrow store at byte 3 blocks
    enq(32'h80, 2'd3, 64'h8877_6655_4433_2211);
    enq(32'h83, 2'd0, 64'h5A);
    run_load(32'h80, 2'd2, 1, 3, 64'h5A33_2211, 0, "R9");
    flush();
    // R9: older blocking store, younger exact store forwards
    enq(32'hA2, 2'd0, 64'h11);
    enq(32'hA2, 2'd1, 64'hBEEF);
    run_load(32'hA2, 2'd1, -1, 0, 64'hBEEF, 1, "R9");
    // R4: same word, untouched byte reads the cache at once
    run_load(32'hA4, 2'd0, -1, 0, 64'h44, 0, "R4");
    run_load(32'hA3, 2'd0, 0, 2, 64'hBE, 0, "R7");
    flush();
  endtask

  task automatic t_drain_lane();
    dr_ready = 0;
    enq(32'h1C6, 2'd1, 64'h1234_CAFE);
    #2;
    chk(dr_valid == 1'b1, "R3", "drain valid", 64'(dr_valid), 64'd1);
    chk(dr_addr == 29'h38, "R3", "drain word address", 64'(dr_addr), 64'h38);
    chk(dr_mask == 8'hC0, "R3", "drain byte mask", 64'(dr_mask), 64'hC0);
    chk(dr_data == 64'hCAFE_0000_0000_0000, "R3", "drain lane data", dr_data, 64'hCAFE_0000_0000_0000);
    flush();
    run_load(32'h1C6, 2'd1, -1, 0, 64'hCAFE, 0, "R3");
  endtask

  task automatic t_full_order();
    dr_ready = 0;
    for (int i = 0; i < 8; i++)
      enq(32'h100 + 32'(i * 8), 2'd3, 64'hF000_0000_0000_0000 | 64'(i));
    #2 chk(st_ready == 1'b0, "R2", "st_ready low when full", 64'(st_ready), 64'd0);
    @(negedge clk);
    st_valid = 1; st_addr = 32'h1F8; st_size = 2'd3; st_data = 64'h0DEAD;
    @(negedge clk);
    st_valid = 0;
    // R11: nothing left while dr_ready was low
    #2 chk(dr_addr == 29'h20, "R11", "head unchanged without dr_ready", 64'(dr_addr), 64'h20);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      dr_ready = 1;
      #2;
      chk(dr_valid == 1'b1, "R3", "drain valid in order", 64'(dr_valid), 64'd1);
      chk(dr_addr == 29'(32'h20 + i), "R3", "drain order address", 64'(dr_addr), 64'(32'h20 + i));
      chk(dr_mask == 8'hFF, "R3", "drain full mask", 64'(dr_mask), 64'hFF);
      chk(dr_data == (64'hF000_0000_0000_0000 | 64'(i)), "R3", "drain order data",
          dr_data, 64'hF000_0000_0000_0000 | 64'(i));
    end
    @(negedge clk);
    #2 chk(dr_valid == 1'b0, "R2", "store offered while full was dropped", 64'(dr_valid), 64'd0);
    dr_ready = 0;
    run_load(32'h1F8, 2'd3, -1, 0, 64'hF7F6_F5F4_F3F2_F1F0, 0, "R2");
  endtask

  initial begin
    #(8 * 200000);
    chk(0, "WDOG", "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    t_reset();
    t_cache_only();
    t_forward();
    t_wide_load();
    t_youngest();
    t_drain_lane();
    t_full_order();
    finish_run();
  end

endmodule